// File: doc/BRIEF.md
# Serial Receive Character Queue

This block sits between the bit-recovery logic of a serial receiver and the host side of a serial port. Each time the deserializer finishes a character it presents the data bits, an optional ninth bit and a stop-bit error indication. The block stores these together in a two-slot circular queue, so that every slot keeps its own status. The host sees the status and data of the oldest slot and removes it by reading.

The deserializer's own holding register is modelled as an extra stage. An accepted character always passes through this stage first. When the queue has room, the character moves into the queue on the next clock. When both slots are occupied, the character stays in the stage and waits. If the next start bit comes while the queue and the stage are all full, the waiting character is lost. The loss is then recorded in the slot of the next character that reaches the queue.

The host must read the status outputs before it pops. Clearing the enable empties the whole path.

Top module: `rxq_receive_buffer`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `rx_ready` is 0 and all the head outputs (`head_data`, `head_bit9`, `head_ferr`, `head_ovr`) are 0.
- R2: A character presented with `frm_valid` is copied into the holding stage at that clock edge. It enters the queue at the next edge, provided a slot is free. From then on `head_data`, `head_bit9` and `head_ferr` show its values, and `rx_ready` is 1.
- R3: Slots leave in arrival order. A clock edge with `host_rd` high and a non-empty queue removes the head slot. Each slot's ninth bit and error flags stay with that slot's data.
- R4: `host_rd` while the queue is empty changes nothing. The outputs stay at their empty values.
- R5: If a character arrives while both slots are full, it stays in the holding stage and the head outputs do not change. On the edge after a pop frees a slot, it moves into the queue.
- R6: A held character stays in the holding stage for any number of cycles while the queue stays full and no `start_det` pulse arrives.
- R7: A `start_det` pulse at an edge where both slots and the holding stage are occupied discards the held character. The next character to enter the queue then carries `head_ovr` = 1. A `start_det` pulse at any other time never causes this.
- R8: The overrun mark belongs to one slot only. It goes away when that slot is popped, and later slots carry `head_ovr` = 0 unless a new loss happens.
- R9: `rx_ready` is 1 exactly when the queue holds at least one slot. A character waiting only in the holding stage does not set it.
- R10: While `rx_en` is 0, at each edge both slots, the holding stage and any pending overrun are cleared, and inputs are ignored. `rx_ready` and all head outputs read 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver enable; 0 flushes the whole path |
| start_det | input | 1 | Pulse: the deserializer has seen a new start bit |
| frm_valid | input | 1 | Pulse: a completed character is on the `frm_*` inputs |
| frm_data | input | 8 | Character data bits |
| frm_bit9 | input | 1 | Optional ninth data bit |
| frm_ferr | input | 1 | Stop-bit (framing) error for this character |
| host_rd | input | 1 | Host data read; pops the head slot |
| rx_ready | output | 1 | Queue holds at least one character |
| head_data | output | 8 | Data of the head slot |
| head_bit9 | output | 1 | Ninth bit of the head slot |
| head_ferr | output | 1 | Framing error of the head slot |
| head_ovr | output | 1 | Overrun mark of the head slot |

## Verification
The bench targets four situations:
- A pop and a transfer from the holding stage on the same edge. A design that got the pointers wrong would duplicate or skip a character.
- A third character parked behind a full queue. A design that got this wrong would raise `rx_ready` too early, or overwrite the head when it should hold it back.
- A start bit against a completely full path, followed by draining. A design that got this wrong would either miss the overrun mark, attach it to the wrong slot, or leave it set after that slot is popped.
- Disabling the receiver with everything occupied. A design that got this wrong would let stale characters or a stale overrun mark survive into the next session.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    parameter int unsigned RXQ_DATA_W = 8;

    typedef struct packed {
        logic                  ovr;
        logic                  ferr;
        logic                  bit9;
        logic [RXQ_DATA_W-1:0] data;
    } rxq_entry_t;

    function automatic rxq_entry_t rxq_make(input logic [RXQ_DATA_W-1:0] d,
                                            input logic b9, input logic fe);
        rxq_entry_t e;
        e.ovr  = 1'b0;
        e.ferr = fe;
        e.bit9 = b9;
        e.data = d;
        return e;
    endfunction

endpackage

// File: rtl/rxq_hold_stage.sv
module rxq_hold_stage
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       frm_valid,
    input  rxq_entry_t frm_entry,
    input  logic       start_det,
    input  logic       q_full,
    output logic       xfer_valid,
    output rxq_entry_t xfer_entry
);

    logic       hold_v;
    rxq_entry_t hold_e;
    logic       ovr_pend;
    logic       drop;

    assign xfer_valid = en && hold_v && !q_full;
    assign drop       = en && hold_v && q_full && start_det;

    always_comb begin
        xfer_entry     = hold_e;
        xfer_entry.ovr = ovr_pend;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hold_v   <= 1'b0;
            hold_e   <= '0;
            ovr_pend <= 1'b0;
        end else begin
            if (frm_valid) begin
                hold_v <= 1'b1;
                hold_e <= frm_entry;
            end else if (xfer_valid || drop) begin
                hold_v <= 1'b0;
            end
            if (xfer_valid)
                ovr_pend <= 1'b0;
            else if (drop)
                ovr_pend <= 1'b1;
        end
    end

    assert_loss_marks_R7: assert property (@(posedge clk) disable iff (rst)
        (en && start_det && hold_v && q_full) |=> ovr_pend);

    assert_hold_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (en && hold_v && q_full && !start_det) |=> hold_v);

    assert_mark_consumed_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !drop) |=> !ovr_pend);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic                          push,
    input  rxq_entry_t                    push_entry,
    input  logic                          pop_req,
    output rxq_entry_t                    head_entry,
    output logic                          full,
    output logic                          nonempty
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    rxq_entry_t       slot [DEPTH];
    logic             pop;

    assign full       = (count == CNT_W'(DEPTH));
    assign nonempty   = (count != '0);
    assign pop        = en && pop_req && nonempty;
    assign head_entry = nonempty ? slot[rd_ptr] : '0;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || !en)
                slot[i] <= '0;
            else if (push && wr_ptr == PTR_W'(i))
                slot[i] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !nonempty && !push) |=> !nonempty);

endmodule

// File: rtl/rxq_receive_buffer.sv
module rxq_receive_buffer
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_en,
    input  logic                  start_det,
    input  logic                  frm_valid,
    input  logic [RXQ_DATA_W-1:0] frm_data,
    input  logic                  frm_bit9,
    input  logic                  frm_ferr,
    input  logic                  host_rd,
    output logic                  rx_ready,
    output logic [RXQ_DATA_W-1:0] head_data,
    output logic                  head_bit9,
    output logic                  head_ferr,
    output logic                  head_ovr
);

    logic       q_full, q_nonempty, xfer_valid;
    rxq_entry_t xfer_entry, head_entry;

    rxq_hold_stage u_hold (
        .clk        (clk),
        .rst        (rst),
        .en         (rx_en),
        .frm_valid  (frm_valid),
        .frm_entry  (rxq_make(frm_data, frm_bit9, frm_ferr)),
        .start_det  (start_det),
        .q_full     (q_full),
        .xfer_valid (xfer_valid),
        .xfer_entry (xfer_entry)
    );

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .en         (rx_en),
        .push       (xfer_valid),
        .push_entry (xfer_entry),
        .pop_req    (host_rd),
        .head_entry (head_entry),
        .full       (q_full),
        .nonempty   (q_nonempty)
    );

    assign rx_ready  = q_nonempty;
    assign head_data = head_entry.data;
    assign head_bit9 = head_entry.bit9;
    assign head_ferr = head_entry.ferr;
    assign head_ovr  = head_entry.ovr;

    assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rx_ready && !head_ovr));

    assert_xfer_visible_R9: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |=> rx_ready);

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> !rx_ready);

endmodule

// File: tb/rxq_receive_buffer_bench.sv
module rxq_receive_buffer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0, start_det = 1'b0, frm_valid = 1'b0;
    logic [7:0] frm_data = '0;
    logic       frm_bit9 = 1'b0, frm_ferr = 1'b0, host_rd = 1'b0;
    logic       rx_ready, head_bit9, head_ferr, head_ovr;
    logic [7:0] head_data;

    int checks = 0, failures = 0, cyc = 0;
    string cur_req = "R1";

    // model state: queue entries packed as {ovr, ferr, bit9, data}
    logic [10:0] mq[$];
    logic        m_hold_v = 1'b0, m_pend = 1'b0;
    logic [10:0] m_hold = '0;

    always #10 clk = ~clk;

    rxq_receive_buffer u_rxq_receive_buffer (
        .clk(clk), .rst(rst), .rx_en(rx_en), .start_det(start_det),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_bit9(frm_bit9),
        .frm_ferr(frm_ferr), .host_rd(host_rd), .rx_ready(rx_ready),
        .head_data(head_data), .head_bit9(head_bit9), .head_ferr(head_ferr),
        .head_ovr(head_ovr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst || !rx_en) begin
            mq.delete();
            m_hold_v = 1'b0;
            m_pend   = 1'b0;
        end else begin
            bit tr, dr;
            tr = m_hold_v && mq.size() < 2;
            dr = !tr && start_det && m_hold_v && mq.size() == 2;
            if (host_rd && mq.size() > 0) void'(mq.pop_front());
            if (tr) mq.push_back({m_pend, m_hold[9:0]});
            if (tr) m_pend = 1'b0;
            else if (dr) m_pend = 1'b1;
            if (frm_valid) begin
                m_hold_v = 1'b1;
                m_hold   = {1'b0, frm_ferr, frm_bit9, frm_data};
            end else if (tr || dr) m_hold_v = 1'b0;
        end
    end

    always @(negedge clk) begin
        logic [11:0] exp_v, act_v;
        exp_v = (mq.size() > 0) ? {1'b1, mq[0]} : 12'h000;
        act_v = {rx_ready, head_ovr, head_ferr, head_bit9, head_data};
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s cycle %0d: {ready,ovr,ferr,bit9,data} actual=%h expected=%h",
                     cur_req, cyc, act_v, exp_v);
        end
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic fe);
        start_det = 1'b1; @(negedge clk); start_det = 1'b0;
        idle(2);
        frm_valid = 1'b1; frm_data = d; frm_bit9 = b9; frm_ferr = fe;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic rd1();
        host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
    endtask

    initial begin
        cur_req = "R1"; idle(3); rst = 1'b0; rx_en = 1'b1; idle(2);
        cur_req = "R2"; send(8'hA5, 1'b1, 1'b0); idle(2); rd1(); idle(1);
        cur_req = "R3"; send(8'h11, 1'b0, 1'b1); send(8'h22, 1'b1, 1'b0); idle(1);
        rd1(); idle(1); rd1(); idle(1);
        cur_req = "R4"; rd1(); rd1(); idle(2);
        cur_req = "R5"; send(8'h31, 1'b0, 1'b0); send(8'h32, 1'b0, 1'b1);
        idle(1); frm_valid = 1'b1; frm_data = 8'h33; frm_bit9 = 1'b1; frm_ferr = 1'b0;
        @(negedge clk); frm_valid = 1'b0;
        cur_req = "R6"; idle(6);
        cur_req = "R9"; rd1(); idle(2); rd1(); rd1(); idle(2);
        cur_req = "R7"; send(8'h41, 1'b0, 1'b0); send(8'h42, 1'b0, 1'b0);
        send(8'h43, 1'b0, 1'b0); idle(1);
        send(8'h44, 1'b1, 1'b1); idle(2);
        start_det = 1'b1; @(negedge clk); start_det = 1'b0; idle(2);
        cur_req = "R8"; rd1(); idle(1); rd1(); idle(1); rd1(); idle(1);
        send(8'h45, 1'b0, 1'b0); idle(2); rd1(); idle(2);
        cur_req = "R10"; send(8'h51, 1'b0, 1'b0); send(8'h52, 1'b0, 1'b0);
        send(8'h53, 1'b0, 1'b0); idle(1);
        start_det = 1'b1; @(negedge clk); start_det = 1'b0;
        rx_en = 1'b0; frm_valid = 1'b1; frm_data = 8'h66; host_rd = 1'b1;
        @(negedge clk); frm_valid = 1'b0; host_rd = 1'b0; idle(2);
        rx_en = 1'b1; idle(2); send(8'h77, 1'b0, 1'b0); idle(2); rd1(); idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule